// File: doc/BRIEF.md
# Complex Twin Butterfly Datapath

This block is the arithmetic heart of a radix-2 FFT stage. Each accepted operation takes a complex low element, a complex high element and one twiddle pair (cosine and sine). It forms a single shared twiddled product from the high element. The block then writes back a pair of results: the low element plus the product replaces the low element, and the low element minus the product replaces the high element. The sum and the difference come from the same full-precision product, so both outputs of the pair are consistent with each other.

The real product term is `tr = hi_re*cos + hi_im*sin`. The imaginary term is `ti = hi_im*cos - hi_re*sin`. All operands are signed 16-bit Q1.15 values. Products and sums are kept at full width. Only the final four results are rounded to nearest and clamped back to 16 bits. A mode input selects real-only operation, in which only the real parts take part in the arithmetic.

The pipeline has three stages (multiply, combine, add/subtract with rounding). It takes one new butterfly on every cycle and never stalls. A sticky flag records that a result was clamped, and a one-cycle pulse clears it. Index sequencing, twiddle storage and memory belong to the surrounding logic.

Top module: `cbfly_top`

## Requirements
- R1: For a complex-mode operation the outputs are new_lo_re = rs(lo_re·2^15 + tr), new_lo_im = rs(lo_im·2^15 + ti), new_hi_re = rs(lo_re·2^15 − tr) and new_hi_im = rs(lo_im·2^15 − ti), where tr = hi_re·tw_cos + hi_im·tw_sin, ti = hi_im·tw_cos − hi_re·tw_sin, all products are exact 32-bit values, and rs is the rounding and clamping of R3 and R4.
- R2: Operands sampled with in_valid high at rising edge k appear on the outputs, with out_valid high, after rising edge k+2. out_valid is low in every other cycle. One operation is accepted every cycle, back to back.
- R3: rs(x) = floor((x + 2^14) / 2^15): the value is rounded to nearest and an exact half rounds toward plus infinity. No intermediate value is rounded.
- R4: A rounded value above 32767 is output as 16'h7FFF, and one below −32768 is output as 16'h8000.
- R5: When real_only is 1, new_lo_re = rs(lo_re·2^15 + hi_re·tw_cos) and new_hi_re = rs(lo_re·2^15 − hi_re·tw_cos). Both imaginary outputs are 0. lo_im, hi_im and tw_sin have no effect.
- R6: sat_flag goes to 1 in the same cycle as a valid result in which any of the four outputs was clamped. Once set, it stays at 1 until it is cleared.
- R7: A sat_clr high at a rising edge makes sat_flag 0 after that edge. If a clamped result is completed at that same edge, the flag is 1 instead (setting wins over clearing).
- R8: While rst_n is low, out_valid, sat_flag and all four data outputs are 0.
- R9: The data outputs hold their last values while out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| real_only | input | 1 | 1 = real-only butterfly, 0 = complex butterfly |
| lo_re | input | 16 | Low element real part, Q1.15 |
| lo_im | input | 16 | Low element imaginary part, Q1.15 |
| hi_re | input | 16 | High element real part, Q1.15 |
| hi_im | input | 16 | High element imaginary part, Q1.15 |
| tw_cos | input | 16 | Twiddle cosine, Q1.15 |
| tw_sin | input | 16 | Twiddle sine, Q1.15 |
| sat_clr | input | 1 | Pulse that clears the sticky saturation flag |
| out_valid | output | 1 | Results are valid this cycle |
| new_lo_re | output | 16 | Updated low element, real part |
| new_lo_im | output | 16 | Updated low element, imaginary part |
| new_hi_re | output | 16 | Updated high element, real part |
| new_hi_im | output | 16 | Updated high element, imaginary part |
| sat_flag | output | 1 | Sticky flag: a result was clamped |

## Verification
A product or a pipelined low operand that is misaligned or wrongly signed shows up as wrong output values on the third edge after the operation enters. In a back-to-back stream it can also show as the values of the neighbouring operation. Corrupted rounding or clamping is only visible on exact half values and on extreme operands, so those values get directed checks. A wrong valid chain or a broken flag register shows up on out_valid or sat_flag within the same three cycles. Real-only masking is checked by loading large imaginary operands and looking at the real outputs, and at the imaginary outputs, which must then be zero.

// File: rtl/cbfly_pkg.sv
package cbfly_pkg;
  localparam int unsigned CBFLY_DW = 16;

  typedef enum logic {
    MODE_CPLX = 1'b0,
    MODE_REAL = 1'b1
  } cbfly_mode_e;
endpackage

// File: rtl/cbfly_mul_stage.sv
module cbfly_mul_stage
  import cbfly_pkg::*;
#(
  parameter int unsigned DW = CBFLY_DW,
  localparam int unsigned PW = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vin,
  input  cbfly_mode_e          mode,
  input  logic signed [DW-1:0] lo_re,
  input  logic signed [DW-1:0] lo_im,
  input  logic signed [DW-1:0] hi_re,
  input  logic signed [DW-1:0] hi_im,
  input  logic signed [DW-1:0] cs,
  input  logic signed [DW-1:0] sn,
  output logic                 vout,
  output cbfly_mode_e          mode_q,
  output logic signed [DW-1:0] lo_re_q,
  output logic signed [DW-1:0] lo_im_q,
  output logic signed [PW-1:0] p_rc,
  output logic signed [PW-1:0] p_is,
  output logic signed [PW-1:0] p_rs,
  output logic signed [PW-1:0] p_ic
);
  localparam int unsigned NPROD = 4;

  function automatic logic signed [PW-1:0] smul(input logic signed [DW-1:0] a,
                                                input logic signed [DW-1:0] b);
    smul = PW'(a) * PW'(b);
  endfunction

  logic                 is_real;
  logic signed [DW-1:0] him_m, sn_m, lim_m;
  logic signed [DW-1:0] op_a [NPROD];
  logic signed [DW-1:0] op_b [NPROD];
  logic signed [PW-1:0] prod_q [NPROD];

  assign is_real = (mode == MODE_REAL);
  assign him_m   = is_real ? '0 : hi_im;
  assign sn_m    = is_real ? '0 : sn;
  assign lim_m   = is_real ? '0 : lo_im;

  assign op_a[0] = hi_re;  assign op_b[0] = cs;
  assign op_a[1] = him_m;  assign op_b[1] = sn_m;
  assign op_a[2] = hi_re;  assign op_b[2] = sn_m;
  assign op_a[3] = him_m;  assign op_b[3] = cs;

  for (genvar g = 0; g < NPROD; g++) begin : g_prod
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   prod_q[g] <= '0;
      else if (vin) prod_q[g] <= smul(op_a[g], op_b[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout    <= 1'b0;
      mode_q  <= MODE_CPLX;
      lo_re_q <= '0;
      lo_im_q <= '0;
    end else begin
      vout <= vin;
      if (vin) begin
        mode_q  <= mode;
        lo_re_q <= lo_re;
        lo_im_q <= lim_m;
      end
    end
  end

  assign p_rc = prod_q[0];
  assign p_is = prod_q[1];
  assign p_rs = prod_q[2];
  assign p_ic = prod_q[3];

  // R5: in real mode the cross products are zero one stage later
  p_real_cross_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vin && mode == MODE_REAL) |=> (p_is == '0 && p_rs == '0 && p_ic == '0));
endmodule

// File: rtl/cbfly_comb_stage.sv
module cbfly_comb_stage
  import cbfly_pkg::*;
#(
  parameter int unsigned DW = CBFLY_DW,
  localparam int unsigned PW = 2 * DW,
  localparam int unsigned TW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vin,
  input  cbfly_mode_e          mode,
  input  logic signed [DW-1:0] lo_re,
  input  logic signed [DW-1:0] lo_im,
  input  logic signed [PW-1:0] p_rc,
  input  logic signed [PW-1:0] p_is,
  input  logic signed [PW-1:0] p_rs,
  input  logic signed [PW-1:0] p_ic,
  output logic                 vout,
  output cbfly_mode_e          mode_q,
  output logic signed [DW-1:0] lo_re_q,
  output logic signed [DW-1:0] lo_im_q,
  output logic signed [TW-1:0] t_re,
  output logic signed [TW-1:0] t_im
);
  function automatic logic signed [TW-1:0] wadd(input logic signed [PW-1:0] a,
                                                input logic signed [PW-1:0] b);
    wadd = TW'(a) + TW'(b);
  endfunction

  function automatic logic signed [TW-1:0] wsub(input logic signed [PW-1:0] a,
                                                input logic signed [PW-1:0] b);
    wsub = TW'(a) - TW'(b);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vout    <= 1'b0;
      mode_q  <= MODE_CPLX;
      lo_re_q <= '0;
      lo_im_q <= '0;
      t_re    <= '0;
      t_im    <= '0;
    end else begin
      vout <= vin;
      if (vin) begin
        mode_q  <= mode;
        lo_re_q <= lo_re;
        lo_im_q <= lo_im;
        t_re    <= wadd(p_rc, p_is);
        t_im    <= wsub(p_ic, p_rs);
      end
    end
  end
endmodule

// File: rtl/cbfly_addsub_stage.sv
module cbfly_addsub_stage
  import cbfly_pkg::*;
#(
  parameter int unsigned DW = CBFLY_DW,
  localparam int unsigned PW   = 2 * DW,
  localparam int unsigned TW   = PW + 1,
  localparam int unsigned SW   = PW + 2,
  localparam int unsigned FRAC = DW - 1,
  localparam int unsigned NL   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vin,
  input  cbfly_mode_e          mode,
  input  logic signed [DW-1:0] lo_re,
  input  logic signed [DW-1:0] lo_im,
  input  logic signed [TW-1:0] t_re,
  input  logic signed [TW-1:0] t_im,
  output logic                 vout,
  output logic signed [DW-1:0] o_lo_re,
  output logic signed [DW-1:0] o_lo_im,
  output logic signed [DW-1:0] o_hi_re,
  output logic signed [DW-1:0] o_hi_im,
  output logic                 sat_hit
);
  localparam logic signed [SW-1:0] RND_HALF = SW'(1) <<< (FRAC - 1);
  localparam logic signed [SW-1:0] SAT_HI = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] SAT_LO = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  // returns {clamped, value}
  function automatic logic [DW:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] r;
    r = (x + RND_HALF) >>> FRAC;
    if (r > SAT_HI)      rnd_sat = {1'b1, SAT_HI[DW-1:0]};
    else if (r < SAT_LO) rnd_sat = {1'b1, SAT_LO[DW-1:0]};
    else                 rnd_sat = {1'b0, r[DW-1:0]};
  endfunction

  logic signed [DW-1:0] lo_in [NL];
  logic signed [TW-1:0] t_in  [NL];
  logic signed [DW-1:0] lo_q  [NL];
  logic signed [DW-1:0] hi_q  [NL];
  logic [NL-1:0]        ovf_lo, ovf_hi;

  assign lo_in[0] = lo_re;  assign t_in[0] = t_re;
  assign lo_in[1] = lo_im;  assign t_in[1] = t_im;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic signed [SW-1:0] base, sum_w, dif_w;
    logic [DW:0]          sum_r, dif_r;

    assign base  = SW'(lo_in[l]) <<< FRAC;
    assign sum_w = base + SW'(t_in[l]);
    assign dif_w = base - SW'(t_in[l]);
    assign sum_r = rnd_sat(sum_w);
    assign dif_r = rnd_sat(dif_w);
    assign ovf_lo[l] = vin & sum_r[DW];
    assign ovf_hi[l] = vin & dif_r[DW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[l] <= '0;
        hi_q[l] <= '0;
      end else if (vin) begin
        lo_q[l] <= sum_r[DW-1:0];
        hi_q[l] <= dif_r[DW-1:0];
      end
    end

    // R4: a clamped lane lands on a rail
    p_sat_clamp_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_lo[l] |=> (lo_q[l] == SAT_HI[DW-1:0] || lo_q[l] == SAT_LO[DW-1:0]));
    p_sat_clamp_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_hi[l] |=> (hi_q[l] == SAT_HI[DW-1:0] || hi_q[l] == SAT_LO[DW-1:0]));
  end

  assign sat_hit = |{ovf_lo, ovf_hi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vout <= 1'b0;
    else        vout <= vin;
  end

  assign o_lo_re = lo_q[0];
  assign o_lo_im = lo_q[1];
  assign o_hi_re = hi_q[0];
  assign o_hi_im = hi_q[1];

  // R5: real mode gives zero imaginary results
  p_real_im_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vin && mode == MODE_REAL) |=> (o_lo_im == '0 && o_hi_im == '0));
  // R9: no update without a valid operation
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !vin |=> ($stable(o_lo_re) && $stable(o_lo_im) && $stable(o_hi_re) && $stable(o_hi_im)));
endmodule

// File: rtl/cbfly_top.sv
module cbfly_top
  import cbfly_pkg::*;
#(
  parameter int unsigned DW = CBFLY_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          real_only,
  input  logic [DW-1:0] lo_re,
  input  logic [DW-1:0] lo_im,
  input  logic [DW-1:0] hi_re,
  input  logic [DW-1:0] hi_im,
  input  logic [DW-1:0] tw_cos,
  input  logic [DW-1:0] tw_sin,
  input  logic          sat_clr,
  output logic          out_valid,
  output logic [DW-1:0] new_lo_re,
  output logic [DW-1:0] new_lo_im,
  output logic [DW-1:0] new_hi_re,
  output logic [DW-1:0] new_hi_im,
  output logic          sat_flag
);
  localparam int unsigned PW = 2 * DW;
  localparam int unsigned TW = PW + 1;

  cbfly_mode_e          mode_in, mode_s1, mode_s2;
  logic                 v_s1, v_s2;
  logic signed [DW-1:0] lre_s1, lim_s1, lre_s2, lim_s2;
  logic signed [PW-1:0] p_rc, p_is, p_rs, p_ic;
  logic signed [TW-1:0] t_re, t_im;
  logic signed [DW-1:0] o_lre, o_lim, o_hre, o_him;
  logic                 sat_hit;

  assign mode_in = real_only ? MODE_REAL : MODE_CPLX;

  cbfly_mul_stage #(.DW(DW)) i_mul (
    .clk(clk), .rst_n(rst_n), .vin(in_valid), .mode(mode_in),
    .lo_re(lo_re), .lo_im(lo_im), .hi_re(hi_re), .hi_im(hi_im),
    .cs(tw_cos), .sn(tw_sin),
    .vout(v_s1), .mode_q(mode_s1), .lo_re_q(lre_s1), .lo_im_q(lim_s1),
    .p_rc(p_rc), .p_is(p_is), .p_rs(p_rs), .p_ic(p_ic)
  );

  cbfly_comb_stage #(.DW(DW)) i_comb (
    .clk(clk), .rst_n(rst_n), .vin(v_s1), .mode(mode_s1),
    .lo_re(lre_s1), .lo_im(lim_s1),
    .p_rc(p_rc), .p_is(p_is), .p_rs(p_rs), .p_ic(p_ic),
    .vout(v_s2), .mode_q(mode_s2), .lo_re_q(lre_s2), .lo_im_q(lim_s2),
    .t_re(t_re), .t_im(t_im)
  );

  cbfly_addsub_stage #(.DW(DW)) i_addsub (
    .clk(clk), .rst_n(rst_n), .vin(v_s2), .mode(mode_s2),
    .lo_re(lre_s2), .lo_im(lim_s2), .t_re(t_re), .t_im(t_im),
    .vout(out_valid),
    .o_lo_re(o_lre), .o_lo_im(o_lim), .o_hi_re(o_hre), .o_hi_im(o_him),
    .sat_hit(sat_hit)
  );

  assign new_lo_re = o_lre;
  assign new_lo_im = o_lim;
  assign new_hi_re = o_hre;
  assign new_hi_im = o_him;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sat_flag <= 1'b0;
    else if (sat_hit) sat_flag <= 1'b1;
    else if (sat_clr) sat_flag <= 1'b0;
  end

  // cycles since reset, saturating, used to window the latency check
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));
  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag);
  p_sat_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !sat_hit) |=> !sat_flag);
  p_sat_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hit |=> (sat_flag && out_valid));
endmodule

// File: tb/test_cbfly_top.sv
module test_cbfly_top;
  localparam int CLK_P = 10;
  localparam int NV = 10;

  // {real_only, lo_re, lo_im, hi_re, hi_im, cos, sin}
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 16'h1000, 16'h0800, 16'h2000, 16'h1000, 16'h4000, 16'h2000},
    {1'b0, 16'hF000, 16'h0400, 16'h3000, 16'hE000, 16'h5A82, 16'hA57E},
    {1'b0, 16'h0123, 16'hFEDC, 16'h4567, 16'hBA98, 16'h7FFF, 16'h0000},
    {1'b0, 16'h0000, 16'h0000, 16'h0001, 16'h0001, 16'h4000, 16'h4000},
    {1'b0, 16'h2AAA, 16'hD555, 16'h1234, 16'h4321, 16'h8000, 16'h7FFF},
    {1'b1, 16'h1000, 16'h7777, 16'h2000, 16'h6666, 16'h4000, 16'h5555},
    {1'b0, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h7FFF},
    {1'b1, 16'hC000, 16'h1234, 16'h8000, 16'h4321, 16'h8000, 16'h1111},
    {1'b0, 16'h0F0F, 16'hF0F0, 16'hFFFF, 16'h0001, 16'h4000, 16'hC000},
    {1'b0, 16'h3FFF, 16'h3FFF, 16'h2000, 16'h2000, 16'h2000, 16'h2000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, real_only, sat_clr;
  logic [15:0] lo_re, lo_im, hi_re, hi_im, tw_cos, tw_sin;
  logic        out_valid, sat_flag;
  logic [15:0] new_lo_re, new_lo_im, new_hi_re, new_hi_im;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P / 2) clk = ~clk;

  cbfly_top i_cbfly_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .real_only(real_only),
    .lo_re(lo_re), .lo_im(lo_im), .hi_re(hi_re), .hi_im(hi_im),
    .tw_cos(tw_cos), .tw_sin(tw_sin), .sat_clr(sat_clr),
    .out_valid(out_valid), .new_lo_re(new_lo_re), .new_lo_im(new_lo_im),
    .new_hi_re(new_hi_re), .new_hi_im(new_hi_im), .sat_flag(sat_flag)
  );

  function automatic longint sx(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  // rounding half up and clamping, returns {clamped, value}
  function automatic logic [16:0] rs(longint x);
    longint r;
    r = (x + 64'sd16384) >>> 15;
    if (r > 32767)  return {1'b1, 16'h7FFF};
    if (r < -32768) return {1'b1, 16'h8000};
    return {1'b0, r[15:0]};
  endfunction

  // returns {sat, lo_re, lo_im, hi_re, hi_im}
  function automatic logic [64:0] model(logic [96:0] v);
    longint lr, li, hr, hi, c, s, tr, ti;
    logic [16:0] a, b, d, e;
    lr = sx(v[95:80]); li = sx(v[79:64]); hr = sx(v[63:48]);
    hi = sx(v[47:32]); c = sx(v[31:16]); s = sx(v[15:0]);
    if (v[96]) begin li = 0; hi = 0; s = 0; end
    tr = hr * c + hi * s;
    ti = hi * c - hr * s;
    a = rs(lr * 32768 + tr);
    b = rs(li * 32768 + ti);
    d = rs(lr * 32768 - tr);
    e = rs(li * 32768 - ti);
    return {a[16] | b[16] | d[16] | e[16], a[15:0], b[15:0], d[15:0], e[15:0]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {new_lo_re, new_lo_im, new_hi_re, new_hi_im};
  endfunction

  task automatic put(logic [96:0] v, logic vld);
    in_valid  = vld;
    real_only = v[96];
    lo_re = v[95:80]; lo_im = v[79:64]; hi_re = v[63:48];
    hi_im = v[47:32]; tw_cos = v[31:16]; tw_sin = v[15:0];
  endtask

  // issue one op at a negedge, return at the negedge where its result is visible
  task automatic one(logic [96:0] v);
    put(v, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] held;
    logic [64:0] m;
    rst_n = 1'b0; sat_clr = 1'b0;
    put('0, 1'b1);
    repeat (3) @(negedge clk);
    // R8 reset state, with in_valid held high during reset
    chk("R8 reset", {out_valid, sat_flag, outs()}, '0);
    rst_n = 1'b1;
    put('0, 1'b0);
    @(negedge clk);

    // R1/R2 streamed table, one op per cycle
    for (int t = 0; t < NV + 3; t++) begin
      if (t >= 3) begin
        m = model(VEC[t-3]);
        chk("R2 valid stream", {63'd0, out_valid}, 64'd1);
        chk("R1 stream data", outs(), m[63:0]);
      end
      if (t < NV) put(VEC[t], 1'b1);
      else        put('0, 1'b0);
      @(negedge clk);
    end
    chk("R2 valid low after stream", {63'd0, out_valid}, 64'd0);
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;

    // R1 hand-computed: 0.125 + 0.25*0.5 -> 0.25 / 0
    one({1'b0, 16'h1000, 16'h0000, 16'h2000, 16'h0000, 16'h4000, 16'h0000});
    chk("R1 directed", outs(), {16'h2000, 16'h0000, 16'h0000, 16'h0000});
    // R1 imaginary path: hi_im*cos = 0.25 -> lo_im 0.25, hi_im -0.25
    one({1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h4000, 16'h4000, 16'h0000});
    chk("R1 imag", outs(), {16'h0000, 16'h2000, 16'h0000, 16'hE000});
    // R1 sign of the sine terms: hi_re*sin enters ti negatively
    one({1'b0, 16'h0000, 16'h0000, 16'h4000, 16'h0000, 16'h0000, 16'h4000});
    chk("R1 sine sign", outs(), {16'h0000, 16'hE000, 16'h0000, 16'h2000});

    // R2 latency of a single op
    put({1'b0, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000}, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    chk("R2 not yet +1", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R2 not yet +2", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    chk("R2 valid +3", {63'd0, out_valid}, 64'd1);
    @(negedge clk);
    chk("R2 single pulse", {63'd0, out_valid}, 64'd0);

    // R3 ties: +half rounds up, -half rounds to zero
    one({1'b0, 16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h4000, 16'h0000});
    chk("R3 positive tie", outs(), {16'h0001, 16'h0000, 16'h0000, 16'h0000});
    one({1'b0, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h4000, 16'h0000});
    chk("R3 negative tie", outs(), {16'h0000, 16'h0000, 16'h0001, 16'h0000});
    chk("R6 no sat yet", {63'd0, sat_flag}, 64'd0);

    // R4 / R6 clamp high, visible with the result
    one({1'b0, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000});
    chk("R4 clamp high", {48'd0, new_lo_re}, 64'h7FFF);
    chk("R6 flag with result", {63'd0, sat_flag}, 64'd1);
    repeat (4) @(negedge clk);
    one({1'b0, 16'h0010, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000});
    chk("R6 sticky", {63'd0, sat_flag}, 64'd1);
    // R7 clear
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;
    chk("R7 cleared", {63'd0, sat_flag}, 64'd0);
    // R4 clamp low
    one({1'b0, 16'h8000, 16'h0000, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000});
    chk("R4 clamp low", {48'd0, new_hi_re}, 64'h8000);
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;
    // R7 set wins over a coincident clear
    put({1'b0, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000, 16'h7FFF, 16'h0000}, 1'b1);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk); sat_clr = 1'b1;
    @(negedge clk); sat_clr = 1'b0;
    chk("R7 set beats clear", {63'd0, sat_flag}, 64'd1);
    sat_clr = 1'b1; @(negedge clk); sat_clr = 1'b0;

    // R5 real-only: imaginary operands and sine ignored
    one({1'b1, 16'h1000, 16'h7FFF, 16'h2000, 16'h7FFF, 16'h4000, 16'h7FFF});
    chk("R5 real only", outs(), {16'h2000, 16'h0000, 16'h0000, 16'h0000});
    chk("R5 no sat from ignored parts", {63'd0, sat_flag}, 64'd0);
    m = model({1'b1, 16'hD000, 16'h8000, 16'h6000, 16'h8000, 16'hA000, 16'h8000});
    one({1'b1, 16'hD000, 16'h8000, 16'h6000, 16'h8000, 16'hA000, 16'h8000});
    chk("R5 real only model", outs(), m[63:0]);

    // R9 hold while idle
    held = outs();
    repeat (5) @(negedge clk);
    chk("R9 hold", outs(), held);

    summary();
    $finish;
  end
endmodule